// File: doc/BRIEF.md
# Up/Down Edge Event Counter

This block counts edges of an external event input in a counter of configurable width, 16 bits by default. An 8-bit mode register sets up the counter. It enables event counting, picks the counted edge, and picks where the count direction comes from: a software up flag or the level of a direction input pin. It also chooses what happens when the count passes its end, and whether the timer drives the pulse output pin.

Software sets up the counter through a simple write/read register port:

| Address | Register | Access |
|---|---|---|
| 0 | mode | read/write |
| 1 | reload | read/write |
| 2 | control: start and up flag | read/write |
| 3 | live count | read-only |

Every overflow or underflow raises a one-cycle interrupt strobe. When pulse output is enabled, each overflow or underflow also toggles the pulse pin. Both external inputs pass through a two-flop synchronizer before the edge detector sees them.

Top module: `edge_event_counter`

## Requirements
- R1: After reset the mode register reads 00h, the count reads 0, and irqOut, pulseOut and pulseOe are all 0.
- R2: A count happens only while control bit 0 (start) is 1, mode bits [1:0] equal 01 and mode bit 5 is 0. Otherwise event edges leave the count unchanged.
- R3: Mode bit 3 selects the counted edge of evtIn: 0 counts falling edges and 1 counts rising edges. Edges of the other polarity are not counted.
- R4: When mode bit 4 is 0, control bit 1 sets the direction (1 counts up, 0 counts down) and dirIn is ignored. When mode bit 4 is 1, dirIn sets the direction (high counts up, low counts down) and control bit 1 is ignored.
- R5: With mode bit 6 at 0 (reload type), a down count from 0 and an up count from all-ones both load the count from the reload register.
- R6: With mode bit 6 at 1 (free-run type), a down count from 0 gives all-ones and an up count from all-ones gives 0.
- R7: Each underflow or overflow drives irqOut high for exactly one clock cycle. A change on evtIn shows in the count and in irqOut at the third rising clock edge after the change.
- R8: pulseOe follows mode bit 2. While that bit is 1, pulseOut toggles once per underflow or overflow. While it is 0, pulseOut is held at 0.
- R9: A write to the reload register while start is 0 also loads the count. A write while start is 1 leaves the count unchanged and takes effect at the next reload.
- R10: Each qualifying edge gives exactly one count, however long evtIn then stays at its new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 mode, 1 reload, 2 control) |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address (3 selects the live count) |
| rdData | output | 16 | Read data, combinational from rdAddr |
| evtIn | input | 1 | External event input, asynchronous |
| dirIn | input | 1 | External direction level, asynchronous |
| pulseOut | output | 1 | Pulse output, toggles on each overflow or underflow |
| pulseOe | output | 1 | Output enable for the pulse pin |
| irqOut | output | 1 | One-cycle overflow/underflow strobe |

## Verification
The hardest case to reach from the ports is a counter end crossing under every combination of edge polarity, direction source, wrap type and pulse enable. In each case the unused direction source must hold the opposite value. The bench sweeps all sixteen combinations of the four mode bits. For each one it preloads the count next to the top or the bottom through a reload write made while stopped. It then runs enough events to cross the end, driving the ignored direction source against the selected one. A separate cycle-exact probe samples the count and the strobe two and three edges after an event change, which pins down the synchronizer latency.

// File: rtl/edge_evt_pkg.sv
`timescale 1ns/1ps
package edge_evt_pkg;
  localparam int MODE_W = 8;

  typedef enum logic [1:0] {
    ADDR_MODE   = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_COUNT  = 2'd3
  } regAddr_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic countEn;     // take one step this cycle
    logic countUp;     // direction of that step
    logic reloadWr;    // reload register write
    logic loadCounter; // copy write data into counter too
    logic freeRun;     // wrap type
    logic pulseEn;     // pulse output enabled
  } ctlStrobes_t;
endpackage

// File: rtl/evt_sync.sv
`timescale 1ns/1ps
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic evtRaw,
  input  logic dirRaw,
  input  logic risingSel,
  output logic evtEdge,
  output logic dirLevel
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] evtChain;
  logic [STAGES-1:0] dirChain;
  logic              evtPrev;
  logic              evtSync;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          evtChain <= '0;
          dirChain <= '0;
        end else begin
          evtChain <= evtRaw;
          dirChain <= dirRaw;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          evtChain <= '0;
          dirChain <= '0;
        end else begin
          evtChain <= {evtChain[STAGES-2:0], evtRaw};
          dirChain <= {dirChain[STAGES-2:0], dirRaw};
        end
      end
    end
  endgenerate

  assign evtSync  = evtChain[LAST];
  assign dirLevel = dirChain[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtPrev <= 1'b0;
    else       evtPrev <= evtSync;
  end

  always_comb begin
    if (risingSel) evtEdge = evtSync & ~evtPrev;
    else           evtEdge = ~evtSync & evtPrev;
  end

  // R10: a detected edge never lasts two cycles
  p_edge_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    evtEdge |=> !evtEdge);
endmodule

// File: rtl/evt_ctrl.sv
`timescale 1ns/1ps
module evt_ctrl
  import edge_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [MODE_W-1:0] wrByte,
  input  logic              evtEdge,
  input  logic              dirLevel,
  output ctlStrobes_t       strobes,
  output logic [MODE_W-1:0] modeReg,
  output logic              startBit,
  output logic              upFlag
);
  localparam logic [1:0] OP_EVENT = 2'b01;

  logic modeOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      startBit <= 1'b0;
      upFlag   <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_MODE) modeReg <= wrByte;
      if (wrAddr == ADDR_CTRL) begin
        startBit <= wrByte[0];
        upFlag   <= wrByte[1];
      end
    end
  end

  assign modeOk = (modeReg[1:0] == OP_EVENT) && !modeReg[5];

  always_comb begin
    strobes.countEn     = startBit && modeOk && evtEdge;
    strobes.countUp     = modeReg[4] ? dirLevel : upFlag;
    strobes.reloadWr    = wrEn && (wrAddr == ADDR_RELOAD);
    strobes.loadCounter = wrEn && (wrAddr == ADDR_RELOAD) && !startBit;
    strobes.freeRun     = modeReg[6];
    strobes.pulseEn     = modeReg[2];
  end

  // R2: wrong operating mode never lets a count through
  p_bad_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[1:0] != OP_EVENT || modeReg[5]) |-> !strobes.countEn);
  // R9: counter preload only while stopped
  p_preload_stopped_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCounter |-> !strobes.countEn);
endmodule

// File: rtl/evt_datapath.sv
`timescale 1ns/1ps
module evt_datapath
  import edge_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reloadVal,
  output logic             irq,
  output logic             pulseOut
);
  localparam logic [CNT_W-1:0] MAX_VAL = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic             wrapNow;
  logic [CNT_W-1:0] wrapVal;
  logic [CNT_W-1:0] stepVal;

  always_comb begin
    wrapNow = strobes.countEn &&
              (strobes.countUp ? (count == MAX_VAL) : (count == '0));
    if (strobes.freeRun) wrapVal = strobes.countUp ? '0 : MAX_VAL;
    else                 wrapVal = reloadVal;
    stepVal = strobes.countUp ? count + ONE : count - ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reloadVal <= '0;
    else if (strobes.reloadWr) reloadVal <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobes.loadCounter) begin
      count <= wrData;
    end else if (strobes.countEn) begin
      count <= wrapNow ? wrapVal : stepVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq      <= 1'b0;
      pulseOut <= 1'b0;
    end else begin
      irq <= wrapNow;
      if (!strobes.pulseEn) pulseOut <= 1'b0;
      else if (wrapNow)     pulseOut <= ~pulseOut;
    end
  end

  // R2: no step and no preload keeps the count
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.countEn && !strobes.loadCounter) |=> $stable(count));
  // R7: strobe is a single cycle
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  // R8: disabled pulse output stays low
  p_pulse_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pulseEn |=> !pulseOut);
  // R6: free-run up step past all-ones lands on zero
  p_free_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.countEn && strobes.countUp && strobes.freeRun && count == MAX_VAL)
      |=> (count == '0) && irq);
endmodule

// File: rtl/edge_event_counter.sv
`timescale 1ns/1ps
module edge_event_counter
  import edge_evt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  input  logic             evtIn,
  input  logic             dirIn,
  output logic             pulseOut,
  output logic             pulseOe,
  output logic             irqOut
);
  localparam int CTRL_PAD = CNT_W - 2;
  localparam int MODE_PAD = CNT_W - MODE_W;

  ctlStrobes_t       strobes;
  logic              evtEdge;
  logic              dirLevel;
  logic [MODE_W-1:0] modeReg;
  logic              startBit;
  logic              upFlag;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  reloadVal;

  evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .evtRaw(evtIn), .dirRaw(dirIn),
    .risingSel(modeReg[3]), .evtEdge(evtEdge), .dirLevel(dirLevel)
  );

  evt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrByte(wrData[MODE_W-1:0]), .evtEdge(evtEdge), .dirLevel(dirLevel),
    .strobes(strobes), .modeReg(modeReg), .startBit(startBit), .upFlag(upFlag)
  );

  evt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .count(count), .reloadVal(reloadVal), .irq(irqOut), .pulseOut(pulseOut)
  );

  assign pulseOe = modeReg[2];

  always_comb begin
    case (rdAddr)
      ADDR_MODE:   rdData = {{MODE_PAD{1'b0}}, modeReg};
      ADDR_RELOAD: rdData = reloadVal;
      ADDR_CTRL:   rdData = {{CTRL_PAD{1'b0}}, upFlag, startBit};
      default:     rdData = count;
    endcase
  end
endmodule

// File: tb/edge_event_counter_tb.sv
`timescale 1ns/1ps
module edge_event_counter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = 2'd0;
  logic [15:0] rdData;
  logic        evtIn = 1'b0;
  logic        dirIn = 1'b0;
  logic        pulseOut, pulseOe, irqOut;

  int checks = 0;
  int errors = 0;
  int irqSeen = 0;
  bit finished = 0;
  logic expPulse = 1'b0;

  edge_event_counter u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evtIn(evtIn), .dirIn(dirIn),
    .pulseOut(pulseOut), .pulseOe(pulseOe), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (rstN && irqOut) irqSeen++;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic pulseEvt(input logic idle);
    @(negedge clk); evtIn = ~idle;
    repeat (4) @(negedge clk);
    evtIn = idle;
    repeat (4) @(negedge clk);
  endtask

  // model: one counted step, returns {wrap, value}
  function automatic logic [16:0] stepModel(input logic [15:0] cur, input logic up,
                                            input logic free, input logic [15:0] rl);
    if (up && cur == 16'hFFFF) return {1'b1, free ? 16'h0000 : rl};
    if (!up && cur == 16'h0000) return {1'b1, free ? 16'hFFFF : rl};
    return {1'b0, up ? cur + 16'd1 : cur - 16'd1};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] expCnt;
    int irqBase;

    repeat (3) @(negedge clk);
    // R1: reset state
    rd(2'd0, v); check("R1 mode", v, 16'h0000);
    rd(2'd3, v); check("R1 count", v, 16'h0000);
    check("R1 irq", {15'd0, irqOut}, 16'd0);
    check("R1 pulse", {14'd0, pulseOut, pulseOe}, 16'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: stopped, events ignored
    wr(2'd0, 16'h0009);           // event mode, rising
    wr(2'd1, 16'd10);             // preload 10 while stopped (R9)
    rd(2'd3, v); check("R9 preload stopped", v, 16'd10);
    wr(2'd2, 16'h0002);           // up flag, not started
    pulseEvt(1'b0);
    rd(2'd3, v); check("R2 stopped no count", v, 16'd10);
    // R2: operating mode 00 ignored while started
    wr(2'd0, 16'h0008);
    wr(2'd2, 16'h0003);
    pulseEvt(1'b0);
    rd(2'd3, v); check("R2 mode00 no count", v, 16'd10);
    // R2: bit5 set ignored
    wr(2'd2, 16'h0002);
    wr(2'd0, 16'h0029);
    wr(2'd2, 16'h0003);
    pulseEvt(1'b0);
    rd(2'd3, v); check("R2 bit5 no count", v, 16'd10);
    // proper mode counts
    wr(2'd2, 16'h0002);
    wr(2'd0, 16'h0009);
    wr(2'd2, 16'h0003);
    pulseEvt(1'b0);
    rd(2'd3, v); check("R2 valid mode counts", v, 16'd11);

    // R10: long high level gives one count only
    @(negedge clk); evtIn = 1'b1;
    repeat (30) @(negedge clk);
    rd(2'd3, v); check("R10 held level single count", v, 16'd12);
    // R3: falling edge with rising selected: not counted
    @(negedge clk); evtIn = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd3, v); check("R3 falling ignored", v, 16'd12);

    // R9: reload write while running leaves count, used at next reload
    wr(2'd1, 16'h0100);
    rd(2'd3, v); check("R9 running write no load", v, 16'd12);
    rd(2'd1, v); check("R9 reload reg", v, 16'h0100);

    // R7: latency probe, down from 0 in reload type
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0001);           // start, down
    wr(2'd1, 16'h0055);           // reload = 55 while running, count stays 0
    rdAddr = 2'd3;
    irqBase = irqSeen;
    @(negedge clk); evtIn = 1'b1;
    @(negedge clk); @(negedge clk);
    #1 check("R7 two edges unchanged", rdData, 16'h0000);
    check("R7 no strobe yet", {15'd0, irqOut}, 16'd0);
    @(negedge clk);
    #1 check("R7 third edge reload", rdData, 16'h0055);
    check("R7 strobe high", {15'd0, irqOut}, 16'd1);
    @(negedge clk);
    #1 check("R7 strobe one cycle", {15'd0, irqOut}, 16'd0);
    @(negedge clk); evtIn = 1'b0;
    repeat (5) @(negedge clk);

    // Sweep of all pulse/edge/dirsrc/freerun combinations (R3..R8)
    for (int cfg = 0; cfg < 16; cfg++) begin
      logic pe, rise, pinDir, free, idle;
      logic [7:0] mode;
      pe = cfg[0]; rise = cfg[1]; pinDir = cfg[2]; free = cfg[3];
      idle = ~rise;
      mode = {1'b0, free, 1'b0, pinDir, rise, pe, 2'b01};
      wr(2'd2, 16'h0000);
      wr(2'd0, {8'd0, mode});
      if (!pe) expPulse = 1'b0;
      @(negedge clk); evtIn = idle;
      repeat (6) @(negedge clk);
      check("R8 oe", {15'd0, pulseOe}, {15'd0, pe});
      for (int run = 0; run < 2; run++) begin
        logic up;
        logic [15:0] rl;
        logic [16:0] r;
        int wraps;
        up = (run == 0);
        rl = up ? 16'hFFFD : 16'h0002;
        wr(2'd1, rl);
        expCnt = rl;
        wraps = 0;
        dirIn = pinDir ? up : ~up;
        wr(2'd2, {14'd0, (pinDir ? ~up : up), 1'b1});
        irqBase = irqSeen;
        for (int e = 0; e < 5; e++) begin
          pulseEvt(idle);
          r = stepModel(expCnt, up, free, rl);
          expCnt = r[15:0];
          if (r[16]) begin
            wraps++;
            if (pe) expPulse = ~expPulse;
          end
        end
        wr(2'd2, 16'h0000);
        rd(2'd3, v);
        check($sformatf("R4 R5 R6 cfg%0d run%0d count", cfg, run), v, expCnt);
        check($sformatf("R7 cfg%0d run%0d strobes", cfg, run),
              16'(irqSeen - irqBase), 16'(wraps));
        check($sformatf("R8 cfg%0d run%0d pulse", cfg, run),
              {15'd0, pulseOut}, {15'd0, expPulse});
      end
    end

    // R3: falling-edge mode ignores rising edges
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'd40);
    @(negedge clk); evtIn = 1'b0;
    repeat (6) @(negedge clk);
    wr(2'd2, 16'h0003);
    @(negedge clk); evtIn = 1'b1;
    repeat (6) @(negedge clk);
    rd(2'd3, v); check("R3 rising ignored in falling mode", v, 16'd40);
    @(negedge clk); evtIn = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd3, v); check("R3 falling counted", v, 16'd41);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule